// File: doc/BRIEF.md
# Transmit descriptor ring engine

The engine walks a ring of transmit descriptors kept in a shared byte-wide memory and turns every frame the host has handed over into a byte stream. Each descriptor occupies eight bytes. The engine reads a status byte, a two-byte length and the frame bytes from a fixed-size buffer tied to the descriptor slot. It sends the bytes downstream on a valid/ready stream that marks the final byte. It then writes the status byte back to hand the slot to the host and pulses a completion signal.

A scan is requested by a one-cycle kick, which the surrounding controller raises on every register write. Kicks are only accepted while the controller is running. A scan begins at the current ring pointer. It ends at the first slot that is not ready, or once every slot in the ring has been visited. A kick that arrives during a scan is held, and it starts one more scan when the current one ends. A length that decodes to zero or to more than a buffer's capacity produces a memory-error pulse. In that case the slot is handed back without sending anything.

Top module: `txr_engine`

## Requirements
- R1: A descriptor is ready only when its status byte (descriptor offset 2) equals exactly 0x83. Any other value ends the scan: no bytes are sent, the status is not written and the ring pointer does not move.
- R2: The length is stored with its high byte at descriptor offset 4 and its low byte at offset 5. It holds the negative byte count, and the count is the bitwise inverse of that 16-bit value plus one.
- R3: The frame bytes are read from buf_base_i + slot*1544 + k, for k from 0 up to count-1. They are emitted in that order, and tx_last_o is high on the final byte only.
- R4: One cycle after the final byte is accepted, the engine writes 0x03 to the slot's status byte and pulses tx_done_o for one cycle. The ring pointer advances by one modulo 16.
- R5: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_last_o hold their values and the memory port stays idle.
- R6: A kick while run_i is high starts a scan at the current ring pointer. The scan wraps from slot 15 to slot 0.
- R7: A scan visits at most 16 slots. A slot made ready again behind the scan is not sent until the next kick. A kick during a scan causes exactly one further scan.
- R8: While run_i is low, kicks are ignored and no memory access or byte transfer takes place. Raising run_i later does not start a scan without a new kick.
- R9: A decoded count of zero or greater than 1544 pulses mem_err_o instead of tx_done_o. The status is rewritten to 0x03, the pointer advances and no bytes are sent.
- R10: After reset the ring pointer is 0, and the stream, the memory port and both pulses are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Controller running (low means stopped) |
| kick_i | input | 1 | Scan request, one cycle per register write |
| desc_base_i | input | AW | Byte address of descriptor slot 0 |
| buf_base_i | input | AW | Byte address of buffer 0 |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid one cycle after the request |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| tx_done_o | output | 1 | Frame sent, slot returned |
| mem_err_o | output | 1 | Bad length, slot returned unsent |
| tx_ptr_o | output | log2(RING) | Current ring pointer |

## Verification
Several properties are checked on every cycle:
- the stream holds steady under backpressure and the memory port stays quiet during a stall;
- the completion pulse follows the final byte by one cycle and coincides with the 0x03 write-back;
- the ring pointer moves by exactly one on each completion or error, and holds otherwise;
- an error never overlaps a stream byte.

The directed scenarios cover the rest. They check that the bytes come from the right buffer in the right order, and that the length decodes correctly at the 1544 boundary. They also check that non-ready status values and stopped-state kicks are refused, that the 16-slot limit holds against a slot re-armed behind the scan, and that a kick during a scan is held.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ST_RD, S_ST_CHK, S_LH_RD, S_LL_RD, S_LEN, S_DATA, S_WB
  } state_e;

  typedef enum logic [1:0] {
    A_STATUS, A_LEN_HI, A_LEN_LO, A_DATA
  } addr_sel_e;

  localparam logic [7:0] STATUS_READY = 8'h83;
  localparam logic [7:0] STATUS_DONE  = 8'h03;
  localparam int OFF_STATUS = 2;
  localparam int OFF_LEN_HI = 4;
  localparam int OFF_LEN_LO = 5;
  localparam int DESC_SHIFT = 3;
endpackage

// File: rtl/txr_len_decode.sv
module txr_len_decode #(
  parameter int BUF_BYTES = 1544,
  parameter int LW        = $clog2(BUF_BYTES + 1)
) (
  input  logic [7:0]    hi_i,
  input  logic [7:0]    lo_i,
  output logic [LW-1:0] count_o,
  output logic          bad_o
);
  logic [15:0] neg_len;

  assign neg_len = (~{hi_i, lo_i}) + 16'd1;
  assign count_o = neg_len[LW-1:0];
  assign bad_o   = (neg_len == 16'd0) || (32'(neg_len) > 32'(BUF_BYTES));
endmodule

// File: rtl/txr_addr_gen.sv
module txr_addr_gen
  import txr_pkg::*;
#(
  parameter int AW        = 24,
  parameter int RING      = 16,
  parameter int BUF_BYTES = 1544,
  parameter int PW        = $clog2(RING),
  parameter int LW        = $clog2(BUF_BYTES + 1)
) (
  input  logic [AW-1:0] desc_base_i,
  input  logic [AW-1:0] buf_base_i,
  input  logic [PW-1:0] ptr_i,
  input  addr_sel_e     sel_i,
  input  logic [LW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] slot_base;
  logic [AW-1:0] buf_off;

  assign slot_base = desc_base_i + (AW'(ptr_i) << DESC_SHIFT);

  // buffer stride: shift when a power of two, multiply otherwise
  generate
    if ((BUF_BYTES & (BUF_BYTES - 1)) == 0) begin : g_shift
      assign buf_off = AW'(ptr_i) << $clog2(BUF_BYTES);
    end else begin : g_mul
      localparam logic [AW-1:0] STRIDE = AW'(BUF_BYTES);
      assign buf_off = AW'(ptr_i) * STRIDE;
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      A_STATUS: addr_o = slot_base + AW'(OFF_STATUS);
      A_LEN_HI: addr_o = slot_base + AW'(OFF_LEN_HI);
      A_LEN_LO: addr_o = slot_base + AW'(OFF_LEN_LO);
      default:  addr_o = buf_base_i + buf_off + AW'(idx_i);
    endcase
  end
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out #(
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          rd_req_o,
  output logic [LW-1:0] rd_idx_o,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          done_o
);
  logic          active_q, pend_q, vld_q, last_q;
  logic [LW-1:0] len_q, idx_q;
  logic [7:0]    data_q;
  logic          issue;

  // one read in flight; the next read waits until the output slot frees
  assign issue = active_q && (idx_q != len_q) && !pend_q && (!vld_q || tx_ready_i);
  assign done_o = vld_q && tx_ready_i && last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      len_q    <= '0;
      idx_q    <= '0;
      data_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pend_q   <= 1'b0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      len_q    <= len_i;
      idx_q    <= '0;
    end else begin
      pend_q <= issue;
      if (issue) idx_q <= idx_q + 1'b1;
      if (pend_q) begin
        data_q <= rd_data_i;
        vld_q  <= 1'b1;
        last_q <= (idx_q == len_q);
      end else if (vld_q && tx_ready_i) begin
        vld_q <= 1'b0;
      end
      if (done_o) active_q <= 1'b0;
    end
  end

  assign rd_req_o   = issue;
  assign rd_idx_o   = idx_q;
  assign tx_data_o  = data_q;
  assign tx_valid_o = vld_q;
  assign tx_last_o  = vld_q && last_q;
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW        = 24,
  parameter int RING      = 16,
  parameter int BUF_BYTES = 1544
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    kick_i,
  input  logic [AW-1:0]           desc_base_i,
  input  logic [AW-1:0]           buf_base_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  input  logic [7:0]              mem_rdata_i,
  output logic [7:0]              tx_data_o,
  output logic                    tx_valid_o,
  output logic                    tx_last_o,
  input  logic                    tx_ready_i,
  output logic                    tx_done_o,
  output logic                    mem_err_o,
  output logic [$clog2(RING)-1:0] tx_ptr_o
);
  localparam int PW = $clog2(RING);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam logic [PW-1:0] LAST_VISIT = PW'(RING - 1);

  state_e        state_q, state_d;
  logic [PW-1:0] ptr_q, visit_q;
  logic          pend_q, err_q;
  logic [7:0]    hi_q;
  addr_sel_e     sel;
  logic [LW-1:0] count;
  logic          bad_len, start_scan, bo_start, bo_req, bo_done;
  logic [LW-1:0] bo_idx;

  assign start_scan = (state_q == S_IDLE) && pend_q && run_i;
  assign bo_start   = (state_q == S_LEN) && !bad_len;

  txr_len_decode #(.BUF_BYTES(BUF_BYTES), .LW(LW)) u_len (
    .hi_i   (hi_q),
    .lo_i   (mem_rdata_i),
    .count_o(count),
    .bad_o  (bad_len)
  );

  txr_byte_out #(.LW(LW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bo_start),
    .len_i     (count),
    .rd_req_o  (bo_req),
    .rd_idx_o  (bo_idx),
    .rd_data_i (mem_rdata_i),
    .tx_data_o (tx_data_o),
    .tx_valid_o(tx_valid_o),
    .tx_last_o (tx_last_o),
    .tx_ready_i(tx_ready_i),
    .done_o    (bo_done)
  );

  txr_addr_gen #(
    .AW(AW), .RING(RING), .BUF_BYTES(BUF_BYTES), .PW(PW), .LW(LW)
  ) u_addr (
    .desc_base_i(desc_base_i),
    .buf_base_i (buf_base_i),
    .ptr_i      (ptr_q),
    .sel_i      (sel),
    .idx_i      (bo_idx),
    .addr_o     (mem_addr_o)
  );

  always_comb begin
    state_d = state_q;
    sel     = A_DATA;
    unique case (state_q)
      S_IDLE:   if (start_scan) state_d = S_ST_RD;
      S_ST_RD: begin
        sel     = A_STATUS;
        state_d = S_ST_CHK;
      end
      S_ST_CHK: state_d = (mem_rdata_i == STATUS_READY && run_i) ? S_LH_RD : S_IDLE;
      S_LH_RD: begin
        sel     = A_LEN_HI;
        state_d = S_LL_RD;
      end
      S_LL_RD: begin
        sel     = A_LEN_LO;
        state_d = S_LEN;
      end
      S_LEN:    state_d = bad_len ? S_WB : S_DATA;
      S_DATA:   if (bo_done) state_d = S_WB;
      S_WB: begin
        sel     = A_STATUS;
        state_d = (visit_q == LAST_VISIT) ? S_IDLE : S_ST_RD;
      end
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      visit_q <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      // kicks only count while running; one held request covers any number
      pend_q  <= run_i && (kick_i || (pend_q && !start_scan));
      if (start_scan) visit_q <= '0;
      if (state_q == S_LL_RD) hi_q <= mem_rdata_i;
      if (state_q == S_LEN) err_q <= bad_len;
      if (state_q == S_WB) begin
        ptr_q   <= ptr_q + 1'b1;
        visit_q <= visit_q + 1'b1;
      end
    end
  end

  assign mem_req_o   = (state_q == S_ST_RD) || (state_q == S_LH_RD) ||
                       (state_q == S_LL_RD) || (state_q == S_WB) || bo_req;
  assign mem_we_o    = (state_q == S_WB);
  assign mem_wdata_o = STATUS_DONE;
  assign tx_done_o   = (state_q == S_WB) && !err_q;
  assign mem_err_o   = (state_q == S_WB) && err_q;
  assign tx_ptr_o    = ptr_q;
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int AW   = 24,
  parameter int RING = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [7:0]              mem_wdata_o,
  input logic [7:0]              tx_data_o,
  input logic                    tx_valid_o,
  input logic                    tx_last_o,
  input logic                    tx_ready_i,
  input logic                    tx_done_o,
  input logic                    mem_err_o,
  input logic [$clog2(RING)-1:0] tx_ptr_o
);
  a_r5_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  a_r5_mem_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |-> !mem_req_o);

  a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> tx_done_o);

  a_r4_done_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> mem_req_o && mem_we_o && mem_wdata_o == 8'h03);

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o || mem_err_o |=> tx_ptr_o == $past(tx_ptr_o) + 1'b1);

  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_done_o || mem_err_o) |=> $stable(tx_ptr_o));

  a_r9_err_unsent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_err_o |-> !tx_valid_o && mem_we_o && !tx_done_o);
endmodule

bind txr_engine txr_engine_chk #(.AW(AW), .RING(RING)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_wdata_o(mem_wdata_o),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_last_o  (tx_last_o),
  .tx_ready_i (tx_ready_i),
  .tx_done_o  (tx_done_o),
  .mem_err_o  (mem_err_o),
  .tx_ptr_o   (tx_ptr_o)
);

// File: tb/txr_engine_tb_top.sv
`timescale 1ns/1ps
module txr_engine_tb_top;
  localparam int AW = 24;
  localparam int DB = 'h100;
  localparam int BB = 'h1000;
  localparam int BUFSZ = 1544;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, kick = 1'b0, ready = 1'b1;
  logic mem_req, mem_we, tx_valid, tx_last, tx_done, mem_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, tx_data;
  logic [7:0] rdata_q = 8'h00;
  logic [3:0] ptr;

  always #2.5 clk = ~clk;

  txr_engine #(.AW(AW), .RING(16), .BUF_BYTES(BUFSZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .kick_i(kick),
    .desc_base_i(AW'(DB)), .buf_base_i(AW'(BB)),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata_q),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .tx_ready_i(ready), .tx_done_o(tx_done), .mem_err_o(mem_err),
    .tx_ptr_o(ptr)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [int];
  logic [7:0] cap_d [$];
  logic       cap_l [$];
  int done_cnt = 0, err_cnt = 0, stall_bad = 0, watch_cnt = 0, watch_addr = -1;
  int bp_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  function automatic logic [7:0] mrd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else rdata_q <= mrd(int'(mem_addr));
      if (!mem_we && int'(mem_addr) == watch_addr) watch_cnt++;
    end
    if (tx_valid && ready) begin
      cap_d.push_back(tx_data);
      cap_l.push_back(tx_last);
    end
    if (tx_done) done_cnt++;
    if (mem_err) err_cnt++;
    if (prev_stall && (!tx_valid || tx_data != prev_data)) stall_bad++;
    prev_stall <= tx_valid && !ready;
    prev_data  <= tx_data;
  end

  always @(negedge clk) begin
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready <= (bp_mode != 0) ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed * 31 + k * 7 + (k >> 8));
  endfunction

  task automatic arm(input int d, input int count, input logic [7:0] st, input int seed);
    logic [15:0] raw;
    raw = 16'(-count);
    mem[DB + 8*d + 2] = st;
    mem[DB + 8*d + 4] = raw[15:8];
    mem[DB + 8*d + 5] = raw[7:0];
    for (int k = 0; k < count && k < BUFSZ; k++) mem[BB + d*BUFSZ + k] = pat(seed, k);
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 20000 && q < 12; i++) begin
      @(negedge clk);
      if (mem_req || tx_valid) q = 0; else q++;
    end
  endtask

  // compares captured bytes starting at offset off against one frame
  task automatic check_frame(input int off, input int d, input int count, input int seed, input string req);
    int bad = 0;
    for (int k = 0; k < count; k++) begin
      if (off + k >= cap_d.size()) begin bad++; break; end
      if (cap_d[off+k] != pat(seed, k)) bad++;
      if (cap_l[off+k] != (k == count - 1)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ptr == 0 && !tx_valid && !mem_req && !tx_done && !mem_err, "R10 reset state",
          {ptr, tx_valid, mem_req, tx_done, mem_err}, 0);
  endtask

  task automatic t_single();
    cap_d.delete(); cap_l.delete(); done_cnt = 0;
    arm(0, 5, 8'h83, 1);
    do_kick(); wait_quiet();
    check(cap_d.size() == 5, "R2 decoded count 5", cap_d.size(), 5);
    check_frame(0, 0, 5, 1, "R3 slot 0 bytes and last flag");
    check(mrd(DB + 2) == 8'h03, "R4 status returned", mrd(DB + 2), 8'h03);
    check(ptr == 1 && done_cnt == 1, "R4 pointer and done", {ptr, 8'(done_cnt)}, 'h101);
    check(!tx_done && !mem_err, "R6 scan finished at non-ready slot", tx_done, 0);
  endtask

  task automatic t_backpressure();
    cap_d.delete(); cap_l.delete(); stall_bad = 0;
    arm(1, 9, 8'h83, 2);
    bp_mode = 1;
    do_kick(); wait_quiet();
    bp_mode = 0;
    check_frame(0, 1, 9, 2, "R5 frame under backpressure");
    check(stall_bad == 0, "R5 data stable while stalled", stall_bad, 0);
    check(ptr == 2, "R4 pointer after slot 1", ptr, 2);
  endtask

  task automatic t_not_ready();
    cap_d.delete(); done_cnt = 0;
    arm(2, 4, 8'h80, 3);
    do_kick(); wait_quiet();
    check(cap_d.size() == 0 && ptr == 2 && mrd(DB + 16 + 2) == 8'h80, "R1 status 0x80 refused",
          cap_d.size(), 0);
    mem[DB + 16 + 2] = 8'h82;
    do_kick(); wait_quiet();
    check(cap_d.size() == 0 && ptr == 2 && mrd(DB + 16 + 2) == 8'h82 && done_cnt == 0,
          "R1 status 0x82 refused", ptr, 2);
  endtask

  task automatic t_bad_len();
    cap_d.delete(); cap_l.delete(); done_cnt = 0; err_cnt = 0;
    arm(2, 0, 8'h83, 4);
    arm(3, BUFSZ + 1, 8'h83, 5);
    arm(4, BUFSZ, 8'h83, 6);
    mem[DB + 40 + 2] = 8'h00;
    do_kick(); wait_quiet();
    check(err_cnt == 2, "R9 two length errors", err_cnt, 2);
    check(mrd(DB + 16 + 2) == 8'h03 && mrd(DB + 24 + 2) == 8'h03, "R9 bad slots returned",
          mrd(DB + 24 + 2), 8'h03);
    check(cap_d.size() == BUFSZ && done_cnt == 1, "R2 full 1544-byte frame", cap_d.size(), BUFSZ);
    check_frame(0, 4, BUFSZ, 6, "R3 slot 4 buffer offset");
    check(ptr == 5, "R9 pointer past bad slots", ptr, 5);
  endtask

  task automatic t_queue();
    cap_d.delete(); cap_l.delete();
    arm(5, 40, 8'h83, 7);
    mem[DB + 48 + 2] = 8'h00;
    watch_addr = DB + 48 + 2; watch_cnt = 0;
    do_kick();
    for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
    do_kick(); wait_quiet();
    check(watch_cnt == 2, "R7 kick during scan gives one more scan", watch_cnt, 2);
    check_frame(0, 5, 40, 7, "R3 slot 5 frame");
    watch_addr = -1;
  endtask

  task automatic t_stopped();
    int reqs = 0;
    cap_d.delete(); cap_l.delete();
    run = 1'b0;
    arm(6, 3, 8'h83, 8);
    do_kick();
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (mem_req) reqs++; end
    check(reqs == 0 && cap_d.size() == 0 && mrd(DB + 48 + 2) == 8'h83, "R8 kick ignored when stopped",
          reqs, 0);
    run = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (mem_req) reqs++; end
    check(reqs == 0 && ptr == 6, "R8 no scan on restart alone", reqs, 0);
    do_kick(); wait_quiet();
    check(ptr == 7, "R8 kick after restart", ptr, 7);
    check_frame(0, 6, 3, 8, "R8 frame after restart");
  endtask

  task automatic t_wrap();
    int exp_off = 0, bad = 0;
    cap_d.delete(); cap_l.delete(); done_cnt = 0;
    for (int d = 0; d < 16; d++) arm(d, 2, 8'h83, 20 + d);
    do_kick();
    for (int i = 0; i < 500 && !tx_done; i++) @(negedge clk);
    @(negedge clk);
    mem[DB + 8*7 + 2] = 8'h83;  // re-armed behind the scan
    wait_quiet();
    check(done_cnt == 16, "R7 at most 16 slots per scan", done_cnt, 16);
    check(ptr == 7 && mrd(DB + 8*7 + 2) == 8'h83, "R7 re-armed slot left pending", ptr, 7);
    for (int i = 0; i < 16; i++) begin
      int d = (7 + i) % 16;
      for (int k = 0; k < 2; k++)
        if (exp_off + k >= cap_d.size() || cap_d[exp_off+k] != pat(20 + d, k)) bad++;
      exp_off += 2;
    end
    check(bad == 0, "R6 wrap-around order from slot 7", bad, 0);
    do_kick(); wait_quiet();
    check(done_cnt == 17 && ptr == 8, "R7 next kick sends re-armed slot", done_cnt, 17);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run = 1'b1;
    t_single();
    t_backpressure();
    t_not_ready();
    t_bad_len();
    t_queue();
    t_stopped();
    t_wrap();
    summary();
  end
endmodule